// File: doc/BRIEF.md
# Multichannel ADC digital sequencer

This block is the digital core of a simultaneous-sampling multichannel converter. A falling edge on the active-low convert-start input freezes the words arriving on every channel input in the same clock cycle. The block then works through the enabled channels one at a time, from the lowest index upward. Each converted word goes into a small per-channel result store. A one-cycle end-of-conversion strobe marks each channel, and a sticky end-of-last-conversion flag marks the end of the frame. The quantiser itself is outside the block: each channel arrives as a ready-made digital word.

Software drives an 8-bit channel mask into the block with a chip-select and write strobe. The new mask only comes into force at the next accepted convert-start. Results come back on a 14-bit bus with a read strobe. Each completed read moves a pointer to the next enabled channel, so a host that reads the store repeatedly sees the enabled channels in ascending order. A shutdown input stops all activity. After shutdown ends, and after reset, convert-start must stay high for a set number of cycles before a conversion can start.

Top module: `mcadc_seq`

## Requirements
- R1: Mask bit n (din[n] at write time) enables channel n when 1 and disables it when 0. Bits at positions NCH and above have no effect: on a 4-channel build, a mask of 8'hF0 behaves like an all-zero mask.
- R2: A mask is taken from din in every cycle where cs_n and wr_n are low and rd_n is high. It governs neither the conversion order nor the read order until the next accepted convert-start falling edge.
- R3: At an accepted convert-start, the block captures the words on all channel inputs (channel i on ch_data[i*14 +: 14]) in the same cycle. Input changes after that cycle do not alter the results of that frame.
- R4: The enabled channels are converted in ascending index order. Each one produces a single-cycle eoc pulse, one per enabled channel, and its result is in the store from the cycle in which eoc is high.
- R5: Take the clock edge that samples conv_n low, after it was high, as edge 0. The first eoc is high after edge FIRST_CYC (16 by default), and each further eoc follows NEXT_CYC (3) edges later. eolc rises together with the last eoc and stays high until the next accepted start or shutdown.
- R6: If a frame starts with an all-zero active mask, eolc is high after edge 0 and no eoc occurs.
- R7: A convert-start falling edge that arrives while a frame is converting is ignored: the eoc count and eoc timing of that frame do not change.
- R8: dout_oe is 1 and dout carries a stored result only while cs_n and rd_n are both low. Otherwise dout_oe is 0 and dout is 0.
- R9: A read completes when rd_n rises while cs_n is low, and that moves the read pointer to the next higher enabled channel, wrapping to the lowest. An accepted start sets the pointer to the lowest channel of the new mask.
- R10: While shdn is high, starts are ignored, a frame in progress is abandoned, and eoc and eolc are low. After reset, or after shdn falls, a start is accepted only once conv_n has been high for WAKE_CYC (20) consecutive cycles.
- R11: In reset, eoc, eolc and dout_oe are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_n | input | 1 | Convert-start, active on its falling edge |
| shdn | input | 1 | Shutdown, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | 8 | Mask write data (bit n enables channel n) |
| ch_data | input | NCH*DW | Channel words, channel i in bits [i*DW +: DW] |
| dout | output | DW | Read data, 0 when not driven |
| dout_oe | output | 1 | Output enable for dout (low means high impedance) |
| eoc | output | 1 | One-cycle strobe per converted channel |
| eolc | output | 1 | Sticky end-of-frame flag |

## Verification
The main function is exercised with masks of all ones, a single lowest channel, a single highest channel, a sparse alternating pattern and a contiguous middle block. These tell apart errors in the eoc count, the first-channel and follow-on latencies, and the ascending order and wrap of reads. After each start the channel inputs are changed, so a capture that tracks the live inputs instead of the frame-start values shows up as wrong read data. Directed cases cover an all-zero mask, a staged write read back under the old mask, a second convert-start during a frame, a shutdown in mid-frame, an early start after wake-up, and the ignored upper mask bits on a four-channel build.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int MAX_CH = 8;
  localparam int IDX_W  = 3;

  typedef enum logic [0:0] {ST_IDLE, ST_CONV} eng_state_e;

  // Lowest set bit at or above lo; MSB of the result flags a hit.
  function automatic logic [IDX_W:0] mcs_find(input logic [MAX_CH-1:0] m, input int lo);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = MAX_CH - 1; i >= 0; i--) begin
      if (m[i] && (i >= lo)) r = {1'b1, IDX_W'(i)};
    end
    return r;
  endfunction
endpackage

// File: rtl/mcs_start_ctl.sv
module mcs_start_ctl #(
  parameter int WAKE_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_n,
  input  logic shdn,
  input  logic busy,
  output logic start
);
  localparam int CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] WAKE_LIM = CW'(WAKE_CYC);

  logic          conv_q, conv_d;
  logic [CW-1:0] wake_q, wake_d;
  logic          ready, fall;

  assign ready = (wake_q == WAKE_LIM);
  assign fall  = conv_q & ~conv_n;
  assign start = fall & ready & ~shdn & ~busy;

  always_comb begin
    conv_d = conv_n;
    wake_d = wake_q;
    if (shdn) begin
      wake_d = '0;
    end else if (!ready) begin
      if (conv_n) wake_d = wake_q + CW'(1);
      else        wake_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_q <= 1'b1;
      wake_q <= '0;
    end else begin
      conv_q <= conv_d;
      wake_q <= wake_d;
    end
  end
endmodule

// File: rtl/mcs_conv_engine.sv
module mcs_conv_engine
  import mcs_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int DW        = 14,
  parameter int FIRST_CYC = 16,
  parameter int NEXT_CYC  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shdn,
  input  logic                 start,
  input  logic                 wr_stb,
  input  logic [7:0]           wr_mask,
  input  logic [NCH*DW-1:0]    ch_data,
  output logic                 busy,
  output logic                 eoc,
  output logic                 eolc,
  output logic [NCH-1:0]       act_mask,
  output logic [IDX_W-1:0]     first_idx,
  output logic                 wr_en,
  output logic [IDX_W-1:0]     wr_idx,
  output logic [DW-1:0]        wr_data
);
  localparam int TMAX = (FIRST_CYC > NEXT_CYC) ? FIRST_CYC : NEXT_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] T_FIRST = TW'(FIRST_CYC - 1);
  localparam logic [TW-1:0] T_NEXT  = TW'(NEXT_CYC - 1);

  eng_state_e         state_q, state_d;
  logic [NCH-1:0]     staged_q, staged_d;
  logic [NCH-1:0]     act_q, act_d;
  logic [IDX_W-1:0]   cur_q, cur_d;
  logic [TW-1:0]      tmr_q, tmr_d;
  logic               eoc_q, eoc_d;
  logic               eolc_q, eolc_d;
  logic [NCH*DW-1:0]  snap_q;

  logic [MAX_CH-1:0]  pad_staged, pad_act;
  logic [IDX_W:0]     first_hit, next_hit;
  logic               slot_done;

  always_comb begin
    pad_staged = '0;
    pad_staged[NCH-1:0] = staged_q;
    pad_act = '0;
    pad_act[NCH-1:0] = act_q;
  end

  assign first_hit = mcs_find(pad_staged, 0);
  assign next_hit  = mcs_find(pad_act, int'(cur_q) + 1);
  assign slot_done = (state_q == ST_CONV) && (tmr_q == '0);

  always_comb begin
    state_d  = state_q;
    staged_d = staged_q;
    act_d    = act_q;
    cur_d    = cur_q;
    tmr_d    = tmr_q;
    eoc_d    = 1'b0;
    eolc_d   = eolc_q;
    if (wr_stb) staged_d = wr_mask[NCH-1:0];
    if (shdn) begin
      state_d = ST_IDLE;
      eolc_d  = 1'b0;
    end else if (start) begin
      act_d   = staged_q;
      cur_d   = first_hit[IDX_W-1:0];
      tmr_d   = T_FIRST;
      eolc_d  = ~first_hit[IDX_W];
      state_d = first_hit[IDX_W] ? ST_CONV : ST_IDLE;
    end else if (state_q == ST_CONV) begin
      if (tmr_q == '0) begin
        eoc_d = 1'b1;
        if (next_hit[IDX_W]) begin
          cur_d = next_hit[IDX_W-1:0];
          tmr_d = T_NEXT;
        end else begin
          state_d = ST_IDLE;
          eolc_d  = 1'b1;
        end
      end else begin
        tmr_d = tmr_q - TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      staged_q <= '0;
      act_q    <= '0;
      cur_q    <= '0;
      tmr_q    <= '0;
      eoc_q    <= 1'b0;
      eolc_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      staged_q <= staged_d;
      act_q    <= act_d;
      cur_q    <= cur_d;
      tmr_q    <= tmr_d;
      eoc_q    <= eoc_d;
      eolc_q   <= eolc_d;
    end
  end

  // Sample-and-hold image of all channels, data path without reset.
  always_ff @(posedge clk) begin
    if (start) snap_q <= ch_data;
  end

  always_comb begin
    wr_data = '0;
    for (int i = 0; i < NCH; i++) begin
      if (cur_q == IDX_W'(i)) wr_data = snap_q[i*DW +: DW];
    end
  end

  assign wr_en     = slot_done & ~shdn;
  assign wr_idx    = cur_q;
  assign busy      = (state_q == ST_CONV);
  assign eoc       = eoc_q;
  assign eolc      = eolc_q;
  assign act_mask  = act_q;
  assign first_idx = first_hit[IDX_W-1:0];
endmodule

// File: rtl/mcs_result_store.sv
module mcs_result_store
  import mcs_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             start,
  input  logic [IDX_W-1:0] first_idx,
  input  logic [NCH-1:0]   act_mask,
  input  logic             cs_n,
  input  logic             rd_n,
  output logic [DW-1:0]    dout,
  output logic             dout_oe
);
  logic [DW-1:0]    mem [NCH];
  logic             rd_q, rd_d;
  logic [IDX_W-1:0] rptr_q, rptr_d;
  logic [MAX_CH-1:0] pad_act;
  logic [IDX_W:0]   up_hit, low_hit;
  logic             rd_end;
  logic [DW-1:0]    rd_word;

  always_comb begin
    pad_act = '0;
    pad_act[NCH-1:0] = act_mask;
  end

  assign up_hit  = mcs_find(pad_act, int'(rptr_q) + 1);
  assign low_hit = mcs_find(pad_act, 0);
  assign rd_end  = rd_n & ~rd_q & ~cs_n;

  always_comb begin
    rd_d   = rd_n;
    rptr_d = rptr_q;
    if (start) begin
      rptr_d = first_idx;
    end else if (rd_end) begin
      if (up_hit[IDX_W])       rptr_d = up_hit[IDX_W-1:0];
      else if (low_hit[IDX_W]) rptr_d = low_hit[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b1;
      rptr_q <= '0;
    end else begin
      rd_q   <= rd_d;
      rptr_q <= rptr_d;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(g))) mem[g] <= wr_data;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rptr_q == IDX_W'(i)) rd_word = mem[i];
    end
  end

  assign dout_oe = ~cs_n & ~rd_n;
  assign dout    = dout_oe ? rd_word : '0;
endmodule

// File: rtl/mcadc_seq.sv
module mcadc_seq
  import mcs_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int DW        = 14,
  parameter int FIRST_CYC = 16,
  parameter int NEXT_CYC  = 3,
  parameter int WAKE_CYC  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_n,
  input  logic              shdn,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [7:0]        din,
  input  logic [NCH*DW-1:0] ch_data,
  output logic [DW-1:0]     dout,
  output logic              dout_oe,
  output logic              eoc,
  output logic              eolc
);
  logic             start_w, busy_w, wr_en_w, wr_stb_w;
  logic [NCH-1:0]   act_w;
  logic [IDX_W-1:0] first_w, wr_idx_w;
  logic [DW-1:0]    wr_data_w;

  assign wr_stb_w = ~cs_n & ~wr_n & rd_n;

  mcs_start_ctl #(.WAKE_CYC(WAKE_CYC)) u_start (
    .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .shdn(shdn),
    .busy(busy_w), .start(start_w)
  );

  mcs_conv_engine #(.NCH(NCH), .DW(DW), .FIRST_CYC(FIRST_CYC), .NEXT_CYC(NEXT_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .shdn(shdn), .start(start_w),
    .wr_stb(wr_stb_w), .wr_mask(din), .ch_data(ch_data),
    .busy(busy_w), .eoc(eoc), .eolc(eolc), .act_mask(act_w),
    .first_idx(first_w), .wr_en(wr_en_w), .wr_idx(wr_idx_w), .wr_data(wr_data_w)
  );

  mcs_result_store #(.NCH(NCH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_w), .wr_idx(wr_idx_w),
    .wr_data(wr_data_w), .start(start_w), .first_idx(first_w),
    .act_mask(act_w), .cs_n(cs_n), .rd_n(rd_n),
    .dout(dout), .dout_oe(dout_oe)
  );
endmodule

// File: rtl/mcs_checker.sv
module mcs_checker #(
  parameter int DW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          rd_n,
  input logic          shdn,
  input logic [DW-1:0] dout,
  input logic          dout_oe,
  input logic          eoc,
  input logic          eolc,
  input logic          start,
  input logic          busy,
  input logic          wr_en
);
  // R8: bus released whenever either strobe is inactive
  p_bus_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> (!dout_oe && dout == '0));

  // R10: shutdown silences both completion flags
  p_shdn_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    shdn |=> (!eoc && !eolc));

  // R5: end-of-frame flag holds until a new start or shutdown
  p_eolc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eolc && !shdn && !start) |=> eolc);

  // R6: an accepted start leads to either a conversion or immediate completion
  p_start_effect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !shdn) |=> (busy || eolc));

  // R5: eolc rises only with the last eoc, or right after a start with no channels
  p_eolc_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eolc) |-> (eoc || $past(start)));

  // R4: the store is written only inside a converting frame
  p_write_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> eoc);
endmodule

bind mcadc_seq mcs_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .shdn(shdn),
  .dout(dout), .dout_oe(dout_oe), .eoc(eoc), .eolc(eolc),
  .start(start_w), .busy(busy_w), .wr_en(wr_en_w)
);

// File: tb/mcadc_seq_bench.sv
`timescale 1ns/1ps
module mcadc_seq_bench;
  localparam int NCH = 8;
  localparam int DW  = 14;
  localparam int FIRST = 16;
  localparam int NEXT  = 3;
  localparam int NV = 5;
  localparam logic [7:0]  VEC_MASK [NV] = '{8'hFF, 8'h01, 8'h80, 8'hA5, 8'h3C};
  localparam logic [13:0] VEC_SEED [NV] = '{14'h0123, 14'h1ABC, 14'h2F00, 14'h0777, 14'h3210};
  localparam int          VEC_NEXP [NV] = '{8, 1, 1, 4, 4};

  logic clk, rst_n, conv_n, shdn, cs_n, rd_n, wr_n;
  logic [7:0] din;
  logic [NCH*DW-1:0] ch_data;
  logic [DW-1:0] dout, s_dout;
  logic dout_oe, eoc, eolc, s_oe, s_eoc, s_eolc;

  int errors = 0;
  int checks = 0;
  int s_n, s_eolc_t;

  mcadc_seq u_mcadc_seq (
    .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .shdn(shdn), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .din(din), .ch_data(ch_data),
    .dout(dout), .dout_oe(dout_oe), .eoc(eoc), .eolc(eolc)
  );

  mcadc_seq #(.NCH(4)) u_small (
    .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .shdn(shdn), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .din(din), .ch_data(ch_data[4*DW-1:0]),
    .dout(s_dout), .dout_oe(s_oe), .eoc(s_eoc), .eolc(s_eolc)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] exp_val(input logic [13:0] seed, input int ch);
    return 14'(seed + 14'(ch * 16'h0457));
  endfunction

  task automatic load_inputs(input logic [13:0] seed);
    for (int i = 0; i < NCH; i++) ch_data[i*DW +: DW] = exp_val(seed, i);
  endtask

  task automatic write_mask(input logic [7:0] m);
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; din = m;
    @(negedge clk); wr_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic do_read(output logic [13:0] v);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
    #1 v = dout;
    @(negedge clk); rd_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
  endtask

  task automatic run_frame(input int extra_at, input int shdn_at,
                           output int n_eoc, output int first_t,
                           output int gap_bad, output int eolc_t);
    int last;
    n_eoc = 0; first_t = -1; gap_bad = 0; eolc_t = -1; last = 0;
    s_n = 0; s_eolc_t = -1;
    @(negedge clk); conv_n = 1'b0;
    for (int t = 0; t <= 70; t++) begin
      if (t > 0) begin
        @(negedge clk);
        conv_n = !(extra_at > 0 && t == extra_at);
        if (shdn_at > 0 && t == shdn_at) shdn = 1'b1;
        if (t == 2) ch_data = ~ch_data;
      end
      @(posedge clk); #1;
      if (eoc) begin
        n_eoc++;
        if (n_eoc == 1) first_t = t;
        else if (t - last != NEXT) gap_bad++;
        last = t;
      end
      if (eolc && eolc_t < 0) eolc_t = t;
      if (s_eoc) s_n++;
      if (s_eolc && s_eolc_t < 0) s_eolc_t = t;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, ft, gb, et;
    logic [13:0] v;
    rst_n = 1'b0; conv_n = 1'b1; shdn = 1'b0; cs_n = 1'b1; rd_n = 1'b1;
    wr_n = 1'b1; din = '0; ch_data = '0;
    repeat (4) @(posedge clk);
    #1;
    chk(!eoc && !eolc && !dout_oe, "R11 reset outputs", {eoc, eolc, dout_oe}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (30) @(negedge clk);

    // Vector table: mask, input seed, expected channel count
    for (int k = 0; k < NV; k++) begin
      int expn, expl, ch;
      write_mask(VEC_MASK[k]);
      load_inputs(VEC_SEED[k]);
      run_frame(0, 0, n, ft, gb, et);
      expn = VEC_NEXP[k];
      expl = FIRST + NEXT * (expn - 1);
      chk(n == expn, "R4 eoc count", n, expn);
      chk(ft == FIRST, "R5 first eoc latency", ft, FIRST);
      chk(gb == 0, "R5 eoc spacing", gb, 0);
      chk(et == expl, "R5 eolc timing", et, expl);
      ch = 0;
      for (int r = 0; r < expn; r++) begin
        while (!VEC_MASK[k][ch]) ch++;
        do_read(v);
        chk(v == exp_val(VEC_SEED[k], ch), "R9 R3 R1 read order and data", v, exp_val(VEC_SEED[k], ch));
        ch++;
      end
      ch = 0;
      while (!VEC_MASK[k][ch]) ch++;
      do_read(v);
      chk(v == exp_val(VEC_SEED[k], ch), "R9 read wrap", v, exp_val(VEC_SEED[k], ch));
    end

    // R6: empty mask
    write_mask(8'h00);
    run_frame(0, 0, n, ft, gb, et);
    chk(n == 0, "R6 no eoc", n, 0);
    chk(et == 0, "R6 eolc at once", et, 0);

    // R2: staged mask does not act before the next start
    write_mask(8'hFF);
    load_inputs(14'h0444);
    run_frame(0, 0, n, ft, gb, et);
    write_mask(8'h01);
    do_read(v);
    chk(v == exp_val(14'h0444, 0), "R2 old mask read 0", v, exp_val(14'h0444, 0));
    do_read(v);
    chk(v == exp_val(14'h0444, 1), "R2 old mask read 1", v, exp_val(14'h0444, 1));
    run_frame(0, 0, n, ft, gb, et);
    chk(n == 1, "R2 new mask after start", n, 1);

    // R7: second convert-start during a frame
    write_mask(8'h0F);
    run_frame(5, 0, n, ft, gb, et);
    chk(n == 4, "R7 count unchanged", n, 4);
    chk(ft == FIRST && et == FIRST + 3 * NEXT, "R7 timing unchanged", et, FIRST + 3 * NEXT);

    // R8: bus enable
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b1; #1;
    chk(!dout_oe && dout == 0, "R8 rd high", {dout_oe, dout}, 0);
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; #1;
    chk(!dout_oe && dout == 0, "R8 cs high", {dout_oe, dout}, 0);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; #1;
    chk(dout_oe == 1'b1, "R8 both low", dout_oe, 1);
    @(negedge clk); rd_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;

    // R10: shutdown mid-frame, early start, wake
    write_mask(8'hFF);
    run_frame(0, 8, n, ft, gb, et);
    chk(n == 0 && et < 0, "R10 frame abandoned", n, 0);
    chk(!eolc, "R10 eolc low in shutdown", eolc, 0);
    @(negedge clk); shdn = 1'b0;
    repeat (10) @(negedge clk);
    run_frame(0, 0, n, ft, gb, et);
    chk(n == 0 && et < 0, "R10 early start ignored", n, 0);
    repeat (25) @(negedge clk);
    run_frame(0, 0, n, ft, gb, et);
    chk(n == 8, "R10 start after wake", n, 8);

    // R1: upper mask bits ignored on a 4-channel build
    write_mask(8'hF1);
    run_frame(0, 0, n, ft, gb, et);
    chk(s_n == 1, "R1 small build one channel", s_n, 1);
    write_mask(8'hF0);
    run_frame(0, 0, n, ft, gb, et);
    chk(s_n == 0, "R1 small build upper bits no eoc", s_n, 0);
    chk(s_eolc_t == 0, "R1 small build empty frame", s_eolc_t, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule